// File: doc/BRIEF.md
# Two-Beat Burst SRAM with Per-Lane Write Masks

This block is a synthesizable behavioural model of a common-I/O synchronous SRAM in which every access moves two data words. One rising-edge clock stands in for a complementary clock pair, so each clock cycle is one beat slot. A command is a single-cycle pulse on an active-low start strobe, together with a direction bit and an address. A write then expects its two data words on the next two beat slots. A read returns its two words after a fixed, parameterised latency.

Storage is split into two internal banks that share the address. The first beat of a burst lives in the even bank and the second in the odd bank. Each data word is divided into 9-bit lanes. Each lane has its own active-low write select, sampled in the same beat as the data it qualifies. The output side has a data bus, an output enable and a valid flag. Commands are issued at least two beat slots apart, so that bursts on the shared data bus do not overlap.

Top module: `sram_b2`

## Requirements
- R1: A command is taken only on a rising edge where `start_n` is 0; that edge captures `addr` and `dir`, where `dir`=1 means read and `dir`=0 means write. A read command writes nothing, even while `wdata` and `lane_we_n` are driven.
- R2: After a write command on edge k, `wdata` sampled on edge k+1 is stored in the even bank and `wdata` on edge k+2 in the odd bank, both at the captured address.
- R3: `lane_we_n[i]` is active low and gates bits [9i+8:9i] of the beat it is sampled with. A lane whose select is 1 keeps its stored value. Each beat uses its own select vector.
- R4: For a read command on edge k, the even-bank word is on `rdata` after edge k+RD_LAT (default 2), and the odd-bank word follows after edge k+RD_LAT+1.
- R5: `rdata_vld` and `rdata_oe` are 1 exactly on read beats. On every other slot both are 0 and `rdata` is all zeros.
- R6: While `start_n` is 1, `addr`, `dir`, `wdata` and `lane_we_n` have no effect: nothing is written and no read beat appears.
- R7: A read issued two slots after a write to the same address returns the newly written words, including the second word, which is written on the read's own edge. Lane masks are honoured.
- R8: A synchronous active-high `rst` clears pending writes, pending reads and the output flags. Stored data survives reset.
- R9: Two reads issued two slots apart produce four consecutive valid beats, with no gap between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Beat-slot clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of pipeline state |
| start_n | input | 1 | Active-low command strobe |
| dir | input | 1 | Access direction, 1 = read, 0 = write |
| addr | input | ADDR_W | Burst address shared by both banks |
| wdata | input | LANES*LANE_W | Write data beat |
| lane_we_n | input | LANES | Active-low per-lane write selects for the current beat |
| rdata | output | LANES*LANE_W | Read data beat, zero when idle |
| rdata_oe | output | 1 | Output enable, stands in for driving the shared bus |
| rdata_vld | output | 1 | Marks slots that carry read data |

## Verification
The bench first fills the array with full-mask writes. It then walks a vector table in which each entry writes a burst and reads it back. The entries use different select patterns per beat: all lanes, no lanes, single lanes, and complementary masks on the two beats. These separate lane gating from beat-to-bank steering, and show whether the masks are applied per beat or per burst. Directed cases then target the remaining behaviour:
- a read two slots behind a write, which exercises the bypass into the odd bank;
- strobe-high stimulus carrying live write data, and a read command with data driven, which would expose writes that should not happen;
- reads two slots apart, which check that the output runs without a gap;
- a reset in the middle of a read, which must drop the beats but keep the stored words.

// File: rtl/sram_b2_pkg.sv
package sram_b2_pkg;
   localparam int LANE_W_DEF = 9;
   localparam int BANKS      = 2;
   typedef enum logic {OP_WR = 1'b0, OP_RD = 1'b1} op_e;
endpackage

// File: rtl/sram_b2_cmd.sv
module sram_b2_cmd
   import sram_b2_pkg::*;
#(
   parameter int ADDR_W = 6
) (
   input  logic                        clk,
   input  logic                        rst,
   input  logic                        start_n,
   input  logic                        dir,
   input  logic [ADDR_W-1:0]           addr,
   output logic [BANKS-1:0]            wr_vld,
   output logic [BANKS-1:0][ADDR_W-1:0] wr_addr,
   output logic                        rd_go,
   output logic [ADDR_W-1:0]           rd_addr
);
   logic wr_cmd;

   assign wr_cmd  = !start_n && (op_e'(dir) == OP_WR);
   assign rd_go   = !start_n && (op_e'(dir) == OP_RD);
   assign rd_addr = addr;

   // beat-slot tracker: stage b writes bank b on the next edge
   always_ff @(posedge clk) begin
      if (rst) begin
         wr_vld <= '0;
      end else begin
         wr_vld <= {wr_vld[BANKS-2:0], wr_cmd};
      end
      wr_addr <= {wr_addr[BANKS-2:0], addr};
   end

   p_wr_chain_r2: assert property (@(posedge clk) disable iff (rst)
      wr_vld[0] |=> wr_vld[1]);

   p_cmd_gap_r9: assert property (@(posedge clk) disable iff (rst)
      !start_n |=> start_n);
endmodule

// File: rtl/sram_b2_bank.sv
module sram_b2_bank #(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = 9
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    we,
   input  logic [ADDR_W-1:0]       waddr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic [LANES-1:0]        wmask_n,
   input  logic                    re,
   input  logic [ADDR_W-1:0]       raddr,
   output logic [LANES*LANE_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   localparam int W     = LANES * LANE_W;

   logic [W-1:0] mem [DEPTH];
   logic [W-1:0] rd_word;
   logic         hit;

   always_ff @(posedge clk) begin
      if (we) begin
         for (int i = 0; i < LANES; i++) begin
            if (!wmask_n[i]) mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
         end
      end
   end

   assign hit = we && (waddr == raddr);

   // lane-wise bypass of a write landing on the same edge as the read
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rd_word[g*LANE_W +: LANE_W] = (hit && !wmask_n[g]) ?
             wdata[g*LANE_W +: LANE_W] : mem[raddr][g*LANE_W +: LANE_W];
   end

   always_ff @(posedge clk) begin
      if (re) rdata <= rd_word;
   end

   p_bypass_full_r7: assert property (@(posedge clk) disable iff (rst)
      (re && we && (waddr == raddr) && (wmask_n == '0)) |=> (rdata == $past(wdata)));
endmodule

// File: rtl/sram_b2_rdpipe.sv
module sram_b2_rdpipe #(
   parameter int W      = 36,
   parameter int RD_LAT = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         go,
   input  logic [W-1:0] q_even,
   input  logic [W-1:0] q_odd,
   output logic [W-1:0] rdata,
   output logic         rdata_vld
);
   logic         s0_vld;
   logic         last_vld;
   logic [W-1:0] last_even, last_odd;
   logic [W-1:0] hold_odd;
   logic         pend_odd;
   logic         out_first;

   if (RD_LAT < 1) begin : g_bad_lat
      $error("RD_LAT must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) s0_vld <= 1'b0;
      else     s0_vld <= go;
   end

   if (RD_LAT == 1) begin : g_direct
      assign last_vld  = s0_vld;
      assign last_even = q_even;
      assign last_odd  = q_odd;
   end else begin : g_pipe
      logic         v  [RD_LAT-1:1];
      logic [W-1:0] pe [RD_LAT-1:1];
      logic [W-1:0] po [RD_LAT-1:1];
      always_ff @(posedge clk) begin
         if (rst) begin
            for (int k = 1; k < RD_LAT; k++) v[k] <= 1'b0;
         end else begin
            v[1] <= s0_vld;
            for (int k = 2; k < RD_LAT; k++) v[k] <= v[k-1];
         end
         pe[1] <= q_even;
         po[1] <= q_odd;
         for (int k = 2; k < RD_LAT; k++) begin
            pe[k] <= pe[k-1];
            po[k] <= po[k-1];
         end
      end
      assign last_vld  = v[RD_LAT-1];
      assign last_even = pe[RD_LAT-1];
      assign last_odd  = po[RD_LAT-1];
   end

   // two-beat serializer
   always_ff @(posedge clk) begin
      if (rst) begin
         rdata     <= '0;
         rdata_vld <= 1'b0;
         pend_odd  <= 1'b0;
         out_first <= 1'b0;
      end else if (last_vld) begin
         rdata     <= last_even;
         rdata_vld <= 1'b1;
         pend_odd  <= 1'b1;
         out_first <= 1'b1;
      end else if (pend_odd) begin
         rdata     <= hold_odd;
         rdata_vld <= 1'b1;
         pend_odd  <= 1'b0;
         out_first <= 1'b0;
      end else begin
         rdata     <= '0;
         rdata_vld <= 1'b0;
         out_first <= 1'b0;
      end
      if (last_vld) hold_odd <= last_odd;
   end

   p_second_beat_r4: assert property (@(posedge clk) disable iff (rst)
      out_first |=> (rdata_vld && !out_first));
endmodule

// File: rtl/sram_b2.sv
module sram_b2
   import sram_b2_pkg::*;
#(
   parameter int ADDR_W = 6,
   parameter int LANES  = 4,
   parameter int LANE_W = LANE_W_DEF,
   parameter int RD_LAT = 2,
   localparam int W     = LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_n,
   input  logic              dir,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      wdata,
   input  logic [LANES-1:0]  lane_we_n,
   output logic [W-1:0]      rdata,
   output logic              rdata_oe,
   output logic              rdata_vld
);
   if (ADDR_W < 1 || LANES < 1 || LANE_W < 1) begin : g_bad_geom
      $error("ADDR_W, LANES and LANE_W must be positive");
   end

   logic [BANKS-1:0]             wr_vld;
   logic [BANKS-1:0][ADDR_W-1:0] wr_addr;
   logic                         rd_go;
   logic [ADDR_W-1:0]            rd_addr;
   logic [W-1:0]                 bank_q [BANKS];

   sram_b2_cmd #(.ADDR_W(ADDR_W)) u_cmd (
      .clk(clk), .rst(rst), .start_n(start_n), .dir(dir), .addr(addr),
      .wr_vld(wr_vld), .wr_addr(wr_addr), .rd_go(rd_go), .rd_addr(rd_addr)
   );

   for (genvar b = 0; b < BANKS; b++) begin : g_bank
      sram_b2_bank #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_bank (
         .clk(clk), .rst(rst),
         .we(wr_vld[b]), .waddr(wr_addr[b]), .wdata(wdata), .wmask_n(lane_we_n),
         .re(rd_go), .raddr(rd_addr), .rdata(bank_q[b])
      );
   end

   sram_b2_rdpipe #(.W(W), .RD_LAT(RD_LAT)) u_rdpipe (
      .clk(clk), .rst(rst), .go(rd_go),
      .q_even(bank_q[0]), .q_odd(bank_q[1]),
      .rdata(rdata), .rdata_vld(rdata_vld)
   );

   assign rdata_oe = rdata_vld;

   p_idle_zero_r5: assert property (@(posedge clk) disable iff (rst)
      !rdata_oe |-> (rdata == '0));
endmodule

// File: tb/sram_b2_tb.sv
module sram_b2_tb_top;
   localparam int ADDR_W = 6;
   localparam int LANES  = 4;
   localparam int LW     = 9;
   localparam int W      = LANES * LW;
   localparam int RD_LAT = 2;
   localparam int NVEC   = 8;

   // fields: addr[21:16] seed[15:8] beat0 selects[7:4] beat1 selects[3:0]
   localparam logic [21:0] VEC [NVEC] = '{
      {6'd3,  8'h11, 4'h0, 4'h0},
      {6'd9,  8'h2C, 4'hF, 4'hF},
      {6'd17, 8'h47, 4'hE, 4'hD},
      {6'd22, 8'h5A, 4'h7, 4'hB},
      {6'd40, 8'h63, 4'h5, 4'hA},
      {6'd41, 8'h7E, 4'hA, 4'h5},
      {6'd63, 8'h81, 4'h0, 4'hF},
      {6'd0,  8'h9F, 4'hF, 4'h0}
   };

   logic clk = 0, rst = 1;
   logic start_n = 1, dir = 0;
   logic [ADDR_W-1:0] addr = '0;
   logic [W-1:0] wdata = '0;
   logic [LANES-1:0] lane_we_n = '1;
   logic [W-1:0] rdata;
   logic rdata_oe, rdata_vld;
   int checks = 0, fails = 0;
   logic [W-1:0] m_even [64];
   logic [W-1:0] m_odd  [64];

   always #5 clk = ~clk;

   sram_b2 #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LW), .RD_LAT(RD_LAT)) dut_i (
      .clk(clk), .rst(rst), .start_n(start_n), .dir(dir), .addr(addr),
      .wdata(wdata), .lane_we_n(lane_we_n),
      .rdata(rdata), .rdata_oe(rdata_oe), .rdata_vld(rdata_vld)
   );

   function automatic logic [W-1:0] mk(input logic [7:0] s, input logic b);
      logic [8:0] x;
      x = {b, s};
      return {x ^ 9'h0A5, x + 9'd77, ~x, x ^ 9'h13C};
   endfunction

   function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [W-1:0] nw,
                                          input logic [LANES-1:0] sel_n);
      logic [W-1:0] r;
      r = old;
      for (int i = 0; i < LANES; i++)
         if (!sel_n[i]) r[i*LW +: LW] = nw[i*LW +: LW];
      return r;
   endfunction

   task automatic step(input logic s, input logic d, input logic [ADDR_W-1:0] a,
                       input logic [W-1:0] wd, input logic [LANES-1:0] we_n);
      start_n = s; dir = d; addr = a; wdata = wd; lane_we_n = we_n;
      @(posedge clk);
      #1;
   endtask

   task automatic idle();
      step(1'b1, 1'b0, 6'd0, '0, '1);
   endtask

   task automatic chk(input string req, input logic [W+1:0] act, input logic [W+1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(req, {rdata_oe, rdata_vld, rdata}, {2'b00, {W{1'b0}}});
   endtask

   task automatic chk_beat(input string req, input logic [W-1:0] e);
      chk(req, {rdata_oe, rdata_vld, rdata}, {2'b11, e});
   endtask

   task automatic wr_cmd_beat0(input logic [ADDR_W-1:0] a, input logic [W-1:0] d0,
                               input logic [LANES-1:0] s0);
      step(1'b0, 1'b0, a, '0, '1);
      step(1'b1, 1'b0, 6'd0, d0, s0);
      m_even[a] = merge(m_even[a], d0, s0);
   endtask

   task automatic wr_burst(input logic [ADDR_W-1:0] a, input logic [W-1:0] d0,
                           input logic [LANES-1:0] s0, input logic [W-1:0] d1,
                           input logic [LANES-1:0] s1);
      wr_cmd_beat0(a, d0, s0);
      step(1'b1, 1'b0, 6'd0, d1, s1);
      m_odd[a] = merge(m_odd[a], d1, s1);
   endtask

   // read command may carry the second beat of a preceding write
   task automatic rd_check(input string req, input logic [ADDR_W-1:0] a,
                           input logic [W-1:0] ovl_d, input logic [LANES-1:0] ovl_s);
      logic [W-1:0] e0, e1;
      e0 = m_even[a];
      e1 = m_odd[a];
      step(1'b0, 1'b1, a, ovl_d, ovl_s);
      for (int i = 1; i < RD_LAT; i++) begin
         idle();
         chk_idle({req, " R4 latency"});
      end
      idle(); chk_beat({req, " R4 beat0"}, e0);
      idle(); chk_beat({req, " R4 beat1"}, e1);
      idle(); chk_idle({req, " R5 after"});
   endtask

   logic done = 0;

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      idle(); idle();
      rst = 0;
      chk_idle("R8 reset state");

      for (int a = 0; a < 64; a++) begin
         m_even[a] = 'x; m_odd[a] = 'x;
         wr_burst(6'(a), mk(8'(a * 3), 1'b0), '0, mk(8'(a * 3), 1'b1), '0);
      end

      // R2 R3 table walk
      for (int v = 0; v < NVEC; v++) begin
         wr_burst(VEC[v][21:16], mk(VEC[v][15:8], 1'b0), VEC[v][7:4],
                  mk(VEC[v][15:8], 1'b1), VEC[v][3:0]);
         rd_check("R2/R3 table", VEC[v][21:16], '0, '1);
      end

      // R7 full and partial bypass
      wr_cmd_beat0(6'd12, 36'h123456789, '0);
      m_odd[12] = merge(m_odd[12], 36'hABCDEF012, '0);
      rd_check("R7 full", 6'd12, 36'hABCDEF012, '0);
      wr_cmd_beat0(6'd13, 36'h0F0F0F0F0, 4'h6);
      m_odd[13] = merge(m_odd[13], 36'hFEDCBA987, 4'h9);
      rd_check("R7 partial", 6'd13, 36'hFEDCBA987, 4'h9);

      // R6 strobe high: nothing taken
      for (int i = 0; i < 4; i++) begin
         step(1'b1, i[0], 6'd20, 36'hDEADBEEF5, '0);
         chk_idle("R6 no read");
      end
      rd_check("R6 unchanged", 6'd20, '0, '1);

      // R1 read command with data driven writes nothing
      step(1'b0, 1'b1, 6'd21, 36'h5A5A5A5A5, '0);
      step(1'b1, 1'b0, 6'd21, 36'h5A5A5A5A5, '0);
      step(1'b1, 1'b0, 6'd21, 36'h5A5A5A5A5, '0);
      idle(); idle();
      rd_check("R1 read no write", 6'd21, '0, '1);

      // R9 gapless reads
      step(1'b0, 1'b1, 6'd30, '0, '1);
      idle();
      step(1'b0, 1'b1, 6'd31, '0, '1);
      chk_beat("R9 a beat0", m_even[30]);
      idle(); chk_beat("R9 a beat1", m_odd[30]);
      idle(); chk_beat("R9 b beat0", m_even[31]);
      idle(); chk_beat("R9 b beat1", m_odd[31]);
      idle(); chk_idle("R9 end");

      // R8 reset mid read, memory kept
      step(1'b0, 1'b1, 6'd5, '0, '1);
      idle();
      rst = 1;
      idle();
      chk_idle("R8 cleared");
      rst = 0;
      for (int i = 0; i < 3; i++) begin
         idle();
         chk_idle("R8 no stale beat");
      end
      rd_check("R8 retained", 6'd5, '0, '1);

      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule